// File: doc/BRIEF.md
# One-Shot Automatic Gain Stepper

This controller chooses the 3-bit gain code of a programmable-gain amplifier stage. Each time the enable input goes from low to high, it loads a default code and opens a gain-adjustment window. The window lasts a fixed number of periods of an external slow oscillator.

While the window is open, a synchronized comparator bit reports whether the averaged load current is above or below its threshold. The controller acts on that bit as follows:

- When the current is below the threshold, it raises the gain one step after a long run of oscillator periods.
- When the current is above the threshold, it lowers the gain one step after a short run of periods.

The code saturates at both ends of its range. When the window closes, the code is frozen for the rest of the transmission. A bypass input, used when current sensing is not fitted, suppresses all adjustment.

The oscillator tick and the comparator bit arrive asynchronously. Each one passes through a flop synchronizer. A tick counts once per rising edge, however long it stays high.

Top module: `gain_window_ctrl`

## Requirements
- R1: After reset, the gain code equals DEFAULT_GAIN (0), and both the window flag and the done flag are low.
- R2: A rising edge on enable loads DEFAULT_GAIN into the gain code, raises the window flag and clears the done flag.
- R3: The window stays open for exactly WINDOW_TICKS (2048) oscillator ticks counted from the enable rising edge. On the 2048th tick the window flag falls and the done flag rises. The two flags are never high together.
- R4: While the window is open with comparator input 0 (current below threshold), the gain code rises by one on every 32nd tick.
- R5: While the window is open with comparator input 1 (current above threshold), the gain code falls by one on every 4th tick.
- R6: The gain code stops at 7 (21 dB) when stepping up and at 0 (0 dB) when stepping down, and never wraps. While the window is open, each clock changes the code by at most one.
- R7: While bypass is high, the gain code does not change, and the step interval count restarts.
- R8: A change of comparator direction restarts the step interval. A partial interval in one direction does not count toward the other.
- R9: After the done flag rises, the gain code is frozen until the next enable rising edge, whatever the comparator does.
- R10: While enable is low, the gain code equals DEFAULT_GAIN, and both flags are low.
- R11: A tick counts only on its rising edge. A tick pulse held high for many clocks counts as one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; the rising edge starts a window |
| osc_tick_i | input | 1 | Asynchronous tick from the slow oscillator |
| cmp_high_i | input | 1 | Asynchronous comparator bit; 1 means averaged current is above the threshold |
| bypass_i | input | 1 | Suppresses gain adjustment |
| gain_o | output | 3 | Gain code; code n selects 3n dB |
| window_o | output | 1 | The adjustment window is open |
| done_o | output | 1 | The window has ended since the last enable rising edge |

## Verification
The hardest situation to reach is a direction reversal in the middle of an interval at a non-saturated code.

The stimulus first climbs the code from 0 to 7 with the comparator low, which takes 224 ticks. It then steps down once, and after that alternates short bursts in each direction. A run of 31 ticks after a reversal must leave the code unchanged, and the 32nd tick must move it.

Saturation at both ends inside a single 2048-tick window, and the frozen code after the window, come from full-length directed windows. Seeded random windows of varying length, with random comparator and bypass segments, are checked tick by tick against a model in the bench.

// File: rtl/gwc_pkg.sv
package gwc_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic open;
        logic done;
    } win_state_t;

    function automatic int unsigned step_code(int unsigned code,
                                              int unsigned max_code,
                                              dir_e        d);
        if (d == DIR_UP)
            return (code >= max_code) ? code : code + 1;
        else
            return (code == 0) ? code : code - 1;
    endfunction

endpackage

// File: rtl/gwc_sync.sv
module gwc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/gwc_window.sv
module gwc_window
    import gwc_pkg::*;
#(
    parameter int WINDOW_TICKS = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic tick_i,
    output logic load_o,
    output logic window_o,
    output logic done_o
);
    localparam int WCNT_W = $clog2(WINDOW_TICKS + 1);

    logic              en_q;
    logic [WCNT_W-1:0] wcnt;
    win_state_t        st;

    assign load_o = en_i & ~en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            wcnt <= '0;
            st   <= '{open: 1'b0, done: 1'b0};
        end else begin
            en_q <= en_i;
            if (!en_i) begin
                wcnt <= '0;
                st   <= '{open: 1'b0, done: 1'b0};
            end else if (load_o) begin
                wcnt <= '0;
                st   <= '{open: 1'b1, done: 1'b0};
            end else if (st.open && tick_i) begin
                if (wcnt == WCNT_W'(WINDOW_TICKS - 1)) begin
                    wcnt <= '0;
                    st   <= '{open: 1'b0, done: 1'b1};
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
            end
        end
    end

    assign window_o = st.open;
    assign done_o   = st.done;
endmodule

// File: rtl/gwc_stepper.sv
module gwc_stepper
    import gwc_pkg::*;
#(
    parameter int GAIN_W       = 3,
    parameter int DEFAULT_GAIN = 0,
    parameter int UP_TICKS     = 32,
    parameter int DN_TICKS     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              load_i,
    input  logic              active_i,
    input  logic              tick_i,
    input  dir_e              dir_i,
    input  logic              bypass_i,
    output logic [GAIN_W-1:0] gain_o
);
    localparam int MAX_LIM = (UP_TICKS > DN_TICKS) ? UP_TICKS : DN_TICKS;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);
    localparam int MAX_CODE = (1 << GAIN_W) - 1;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_step;
    logic [GAIN_W-1:0] gain_q;
    dir_e              last_dir;

    always_comb begin
        last_step = (dir_i == DIR_DOWN) ? CNT_W'(DN_TICKS - 1) : CNT_W'(UP_TICKS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q   <= GAIN_W'(DEFAULT_GAIN);
            cnt      <= '0;
            last_dir <= DIR_UP;
        end else begin
            last_dir <= dir_i;
            if (!en_i || load_i) begin
                gain_q <= GAIN_W'(DEFAULT_GAIN);
                cnt    <= '0;
            end else if (bypass_i || (dir_i != last_dir)) begin
                cnt <= '0;
            end else if (active_i && tick_i) begin
                if (cnt == last_step) begin
                    cnt    <= '0;
                    gain_q <= GAIN_W'(step_code(int'(gain_q), MAX_CODE, dir_i));
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign gain_o = gain_q;
endmodule

// File: rtl/gain_window_ctrl.sv
module gain_window_ctrl
    import gwc_pkg::*;
#(
    parameter int GAIN_W       = 3,
    parameter int DEFAULT_GAIN = 0,
    parameter int WINDOW_TICKS = 2048,
    parameter int UP_TICKS     = 32,
    parameter int DN_TICKS     = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              osc_tick_i,
    input  logic              cmp_high_i,
    input  logic              bypass_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              window_o,
    output logic              done_o
);
    logic tick_s;
    logic tick_d;
    logic tick_pulse;
    logic cmp_s;
    logic load;
    dir_e dir;

    gwc_sync #(.STAGES(SYNC_STAGES)) u_tick_sync (
        .clk (clk),
        .rst (rst),
        .d_i (osc_tick_i),
        .q_o (tick_s)
    );

    gwc_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_high_i),
        .q_o (cmp_s)
    );

    always_ff @(posedge clk) begin
        if (rst) tick_d <= 1'b0;
        else     tick_d <= tick_s;
    end

    assign tick_pulse = tick_s & ~tick_d;
    assign dir        = cmp_s ? DIR_DOWN : DIR_UP;

    gwc_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_window (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_i),
        .tick_i   (tick_pulse),
        .load_o   (load),
        .window_o (window_o),
        .done_o   (done_o)
    );

    gwc_stepper #(
        .GAIN_W       (GAIN_W),
        .DEFAULT_GAIN (DEFAULT_GAIN),
        .UP_TICKS     (UP_TICKS),
        .DN_TICKS     (DN_TICKS)
    ) u_stepper (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_i),
        .load_i   (load),
        .active_i (window_o),
        .tick_i   (tick_pulse),
        .dir_i    (dir),
        .bypass_i (bypass_i),
        .gain_o   (gain_o)
    );
endmodule

// File: rtl/gwc_checker.sv
module gwc_checker #(
    parameter int GAIN_W       = 3,
    parameter int DEFAULT_GAIN = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input logic              bypass_i,
    input logic [GAIN_W-1:0] gain_o,
    input logic              window_o,
    input logic              done_o
);
    AST_RISE_LOADS: assert property (@(posedge clk) disable iff (rst)
        $rose(en_i) |=> (window_o && !done_o && gain_o == GAIN_W'(DEFAULT_GAIN))); // R2

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(window_o && done_o)); // R3

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (window_o && en_i) |=>
            ({1'b0, gain_o} == {1'b0, $past(gain_o)} ||
             {1'b0, gain_o} == {1'b0, $past(gain_o)} + 1'b1 ||
             {1'b0, gain_o} == {1'b0, $past(gain_o)} - 1'b1)); // R6

    AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bypass_i && en_i && !$rose(en_i)) |=> $stable(gain_o)); // R7

    AST_FROZEN_AFTER: assert property (@(posedge clk) disable iff (rst)
        (done_o && en_i) |=> $stable(gain_o)); // R9

    AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (gain_o == GAIN_W'(DEFAULT_GAIN) && !window_o && !done_o)); // R10
endmodule

bind gain_window_ctrl gwc_checker #(
    .GAIN_W       (GAIN_W),
    .DEFAULT_GAIN (DEFAULT_GAIN)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en_i),
    .bypass_i (bypass_i),
    .gain_o   (gain_o),
    .window_o (window_o),
    .done_o   (done_o)
);

// File: tb/test_gain_window_ctrl.sv
`timescale 1ns/1ps
module test_gain_window_ctrl;
    localparam int WIN = 2048;
    localparam int UPN = 32;
    localparam int DNN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0;
    logic       osc_tick_i = 1'b0;
    logic       cmp_high_i = 1'b0;
    logic       bypass_i = 1'b0;
    logic [2:0] gain_o;
    logic       window_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_gain = 0;
    int m_wcnt = 0;
    int m_cnt  = 0;
    bit m_win  = 0;
    bit m_done = 0;
    bit m_dir  = 0;
    bit m_byp  = 0;

    always #2.5 clk = ~clk;

    gain_window_ctrl i_gain_window_ctrl (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .osc_tick_i (osc_tick_i),
        .cmp_high_i (cmp_high_i),
        .bypass_i   (bypass_i),
        .gain_o     (gain_o),
        .window_o   (window_o),
        .done_o     (done_o)
    );

    function automatic int next_code(int code, bit down);
        if (down) return (code == 0) ? 0 : code - 1;
        return (code == 7) ? 7 : code + 1;
    endfunction

    task automatic check_all(string tag);
        checks++;
        if (int'(gain_o) != m_gain || window_o != m_win || done_o != m_done) begin
            errors++;
            $display("FAIL %s: gain=%0d win=%0b done=%0b expected gain=%0d win=%0b done=%0b",
                     tag, gain_o, window_o, done_o, m_gain, m_win, m_done);
        end
    endtask

    task automatic clocks(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic model_tick();
        if (m_win) begin
            if (!m_byp) begin
                m_cnt++;
                if (m_cnt == (m_dir ? DNN : UPN)) begin
                    m_cnt  = 0;
                    m_gain = next_code(m_gain, m_dir);
                end
            end
            m_wcnt++;
            if (m_wcnt == WIN) begin
                m_win  = 0;
                m_done = 1;
            end
        end
    endtask

    task automatic tick(string tag, int high_clks = 2);
        @(negedge clk);
        osc_tick_i = 1'b1;
        clocks(high_clks);
        osc_tick_i = 1'b0;
        clocks(4);
        model_tick();
        check_all(tag);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic set_cmp(bit d);
        @(negedge clk);
        cmp_high_i = d;
        if (d != m_dir) m_cnt = 0;
        m_dir = d;
        clocks(4);
    endtask

    task automatic set_byp(bit b);
        @(negedge clk);
        bypass_i = b;
        m_byp = b;
        if (b) m_cnt = 0;
        clocks(2);
    endtask

    task automatic set_en(bit e, string tag);
        @(negedge clk);
        en_i = e;
        if (e) begin
            m_gain = 0; m_wcnt = 0; m_cnt = 0; m_win = 1; m_done = 0;
        end else begin
            m_gain = 0; m_win = 0; m_done = 0;
        end
        clocks(3);
        check_all(tag);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        clocks(4);
        rst = 1'b0;
        clocks(2);
        check_all("R1 reset state");

        // R2, R4, R6, R3: full window climbing from 0
        set_en(1'b1, "R2 enable rise");
        set_cmp(1'b0);
        ticks(UPN - 1, "R4 no step before 32 ticks");
        tick("R4 step on 32nd tick");
        ticks(7 * UPN, "R6 saturate at 7");
        ticks(WIN - 1 - 8 * UPN, "R3 window still open");
        tick("R3 window closes on 2048th tick");
        // R9: frozen after window
        set_cmp(1'b1);
        ticks(40, "R9 frozen after done");

        // R10: enable low
        set_en(1'b0, "R10 enable low idle");
        ticks(10, "R10 ticks ignored while idle");

        // R5, R6, R8, R7, R11
        set_en(1'b1, "R2 second enable rise");
        set_cmp(1'b1);
        ticks(12, "R6 hold at 0 going down");
        set_cmp(1'b0);
        ticks(7 * UPN, "R4 climb to 7");
        set_cmp(1'b1);
        ticks(DNN - 1, "R5 no step before 4 ticks");
        tick("R5 step on 4th tick");
        ticks(2 * DNN, "R5 two more steps");
        set_cmp(1'b0);
        ticks(20, "R8 partial up interval");
        set_cmp(1'b1);
        ticks(3, "R8 partial down interval");
        set_cmp(1'b0);
        ticks(UPN - 1, "R8 restart: no step at 31");
        tick("R8 restart: step at 32");
        set_byp(1'b1);
        set_cmp(1'b1);
        ticks(50, "R7 bypass holds gain");
        set_byp(1'b0);
        ticks(DNN, "R7 adjustment resumes after bypass");
        tick("R11 long tick counts once", 25);
        tick("R11 long tick counts once", 25);
        tick("R11 long tick counts once", 25);
        tick("R11 long tick counts once", 25);

        // random windows
        for (int w = 0; w < 5; w++) begin
            int total;
            set_en(1'b0, "R10 idle between windows");
            set_en(1'b1, "R2 random window start");
            total = 200 + int'($urandom_range(0, 2200));
            while (total > 0) begin
                int seg;
                seg = 1 + int'($urandom_range(0, 60));
                if (seg > total) seg = total;
                set_cmp(1'($urandom_range(0, 1)));
                set_byp(($urandom_range(0, 7) == 0) ? 1'b1 : 1'b0);
                ticks(seg, "R4/R5/R6/R7/R8/R9 random");
                total -= seg;
            end
        end
        set_byp(1'b0);
        set_en(1'b0, "R10 final idle");
        report();
    end
endmodule